// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous on-chip logic read and write an external asynchronous static RAM of 32K words by 8 bits. The client side is a single-cycle handshake. When `ready` is high, a one-cycle pulse on `req` starts an access. `req_we` selects a write or a read, and the address and write data are captured in the same cycle. A read returns its byte on `rd_data` together with a one-cycle `rd_valid` pulse.

On the memory side the block drives the active-low chip select, write strobe and output enable, and the address. It also drives an outgoing data byte with a separate driver-enable; the pad buffer that merges these onto the shared bus sits outside the block. Every access is a fixed run of clock-counted phases. Each phase length is worked out at elaboration from the clock period and the memory's nanosecond limits, which are parameters, so one netlist fits either speed grade. Between accesses the chip select is held high, which keeps the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever idle, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `ready` is 1 and `rd_valid` is 0.
- R2: `ready` is 1 only in idle. A request is taken when `req` and `ready` are both 1 at a clock edge. `req` while `ready` is 0 is ignored and leaves the memory-side outputs unchanged.
- R3: A write (`req_we`=1) runs three phases after the accepting edge. First, TURN cycles with chip select 0, strobe 1 and the driver off. Second, PW cycles with strobe 0 and the driver on. Third, HOLD cycles with strobe back at 1, chip select still 0 and the driver still on. With a 20 ns clock and the fast-grade limits these are 1, 2 and 1 cycles.
- R4: Output enable stays 1 for the whole of every write. The data driver is never on while output enable is 0.
- R5: The address and write data are latched at acceptance. They stay constant on `sram_addr` and `sram_dq_out` for as long as chip select is 0.
- R6: A read (`req_we`=0) holds chip select 0, output enable 0, strobe 1 and the driver off for RD cycles. The bus is sampled on the last of these cycles. In the following cycle `rd_valid` is 1 for one cycle with that byte on `rd_data`. With a 20 ns clock and fast-grade limits RD is 3.
- R7: After every access at least one cycle has chip select 1 before the next access begins.
- R8: Phase counts are the ceiling of each limit divided by the clock period, with a minimum of one cycle. TURN comes from the memory's bus-release time. PW is the larger of the strobe-low and data-setup counts. HOLD is the write-cycle count less TURN and PW, but at least 1. RD is the largest of the address-access, enable-access and read-cycle counts.
- R9: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, sampled while ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | High in idle; a request may be given |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle pulse, rd_data is fresh |
| sram_addr | output | 15 | Address to the memory |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Byte driven toward the memory |
| sram_dq_oe | output | 1 | Driver enable for sram_dq_out |
| sram_dq_in | input | 8 | Byte read back from the bus |

## Verification
The first memory-side phase appears in the cycle right after the accepting edge. Each later phase begins exactly its predecessor's length later. For a read, `rd_valid` and `rd_data` appear one cycle after the last read-phase cycle, so a default read shows its data four cycles after acceptance. The bench computes these counts from the nanosecond limits with its own ceiling arithmetic. It keeps a queue of expected per-cycle output states, filled when a request is taken, and compares every output in the middle of every clock cycle, away from the edges. A behavioural memory on the bus captures data on the strobe's rising edge. Read results are compared against the bench's own record of what was written.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM access sequencer.
// Assumes all timing limits are given in whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_W_ADDR  = 3'd1,
        ST_W_PULSE = 3'd2,
        ST_W_HOLD  = 3'd3,
        ST_R_ACC   = 3'd4
    } seq_state_t;

    // Clock count covering a nanosecond limit, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of one access phase.
// Assumes load_val = phase length minus one; 'last' is high on the final cycle.
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    // R8
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_access_fsm.sv
// Phase sequencer: walks through the write or read phases of one access.
// Assumes each *_CYC parameter is at least one and fits in CW bits.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned PW_CYC   = 2,
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned RD_CYC   = 3,
    parameter int          CW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          ph_last,
    output seq_state_t    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept
);

    localparam logic [CW-1:0] TURN_V = CW'(TURN_CYC - 1);
    localparam logic [CW-1:0] PW_V   = CW'(PW_CYC - 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] RD_V   = CW'(RD_CYC - 1);

    seq_state_t nxt;

    // Next phase and timer reload for the phase being entered.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: if (req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                nxt      = req_we ? ST_W_ADDR : ST_R_ACC;
                tmr_val  = req_we ? TURN_V : RD_V;
            end
            ST_W_ADDR: if (ph_last) begin
                nxt = ST_W_PULSE; tmr_load = 1'b1; tmr_val = PW_V;
            end
            ST_W_PULSE: if (ph_last) begin
                nxt = ST_W_HOLD; tmr_load = 1'b1; tmr_val = HOLD_V;
            end
            ST_W_HOLD: if (ph_last) nxt = ST_IDLE;
            ST_R_ACC:  if (ph_last) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R7
    back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_W_HOLD || state == ST_R_ACC) && ph_last) |=> (state == ST_IDLE));

    // R3
    write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_W_PULSE && $past(state) != ST_W_PULSE) |-> ($past(state) == ST_W_ADDR));

endmodule

// File: rtl/sram_async_ctrl.sv
// Synchronous controller for a 32K x 8 asynchronous static RAM.
// Derives every phase length from CLK_NS and the memory limits, latches
// each request, and decodes the strobes from the current phase.
// Assumes an external pad merges sram_dq_out/sram_dq_oe/sram_dq_in.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          AW       = 15,
    parameter int          DW       = 8,
    parameter int unsigned CLK_NS   = 20,
    parameter int unsigned T_WP_NS  = 40,   // strobe low time
    parameter int unsigned T_WC_NS  = 55,   // write cycle
    parameter int unsigned T_DS_NS  = 25,   // data setup to strobe rise
    parameter int unsigned T_AA_NS  = 55,   // address access
    parameter int unsigned T_OE_NS  = 30,   // enable access
    parameter int unsigned T_RC_NS  = 55,   // read cycle
    parameter int unsigned T_REL_NS = 20    // memory bus release
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] sram_addr,
    output logic          sram_cs_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    localparam int unsigned TURN_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int unsigned PW_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
    localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = (WC_CYC > TURN_CYC + PW_CYC) ? WC_CYC - TURN_CYC - PW_CYC : 1;
    localparam int unsigned RD_CYC   = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                            ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int unsigned MAX_CYC  = max2(max2(TURN_CYC, PW_CYC), max2(HOLD_CYC, RD_CYC));
    localparam int          CW       = $clog2(MAX_CYC + 1);

    seq_state_t    state;
    logic          tmr_load, ph_last, accept;
    logic [CW-1:0] tmr_val;

    sram_access_fsm #(
        .TURN_CYC(TURN_CYC), .PW_CYC(PW_CYC), .HOLD_CYC(HOLD_CYC),
        .RD_CYC(RD_CYC), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .ph_last(ph_last), .state(state), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .accept(accept)
    );

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .last(ph_last)
    );

    // Capture address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
        end
    end

    // Register the bus on the final read cycle and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (state == ST_R_ACC) && ph_last;
            if ((state == ST_R_ACC) && ph_last) rd_data <= sram_dq_in;
        end
    end

    // Strobe decode from the current phase.
    always_comb begin
        ready      = (state == ST_IDLE);
        sram_cs_n  = (state == ST_IDLE);
        sram_we_n  = (state != ST_W_PULSE);
        sram_oe_n  = (state != ST_R_ACC);
        sram_dq_oe = (state == ST_W_PULSE) || (state == ST_W_HOLD);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe || !sram_we_n) |-> sram_oe_n);

    // R5
    addr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    // R3
    hold_past_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_cs_n && sram_dq_oe));

    // R6
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!sram_oe_n) && ready));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int CLK_NS = 20;
    localparam int NOPS   = 48;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R8: expected phase lengths from the fast-grade limits
    localparam int TURN = cyc(20);
    localparam int PW   = mx(cyc(40), cyc(25));
    localparam int HOLD = (cyc(55) > TURN + PW) ? cyc(55) - TURN - PW : 1;
    localparam int RD   = mx(mx(cyc(55), cyc(30)), cyc(55));

    typedef struct packed {
        logic        rdy;
        logic        cs_n;
        logic        we_n;
        logic        oe_n;
        logic        drv;
        logic        rv;
        logic [14:0] addr;
        logic [7:0]  data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic ready, rd_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  rd_data, sram_dq_out, sram_dq_in, rd_word;
    logic [14:0] sram_addr;

    int total = 0, bad = 0;
    bit done = 0;
    exp_t q[$];
    logic [7:0] mem_m [int];
    logic [7:0] exp_mem [int];

    always #10 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Behavioural memory: stores on the strobe's rising edge while selected.
    always @(posedge sram_we_n)
        if (!sram_cs_n) mem_m[int'(sram_addr)] = sram_dq_oe ? sram_dq_out : 8'hEE;
    always @(negedge clk)
        rd_word <= mem_m.exists(int'(sram_addr)) ? mem_m[int'(sram_addr)] : 8'h00;
    assign sram_dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ? rd_word : 8'h00;

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R1/R2 ready", 32'(ready), 32'(e.rdy));
        chk("R3/R7 cs_n", 32'(sram_cs_n), 32'(e.cs_n));
        chk("R3 we_n", 32'(sram_we_n), 32'(e.we_n));
        chk("R4/R6 oe_n", 32'(sram_oe_n), 32'(e.oe_n));
        chk("R3/R4 dq_oe", 32'(sram_dq_oe), 32'(e.drv));
        chk("R6 rd_valid", 32'(rd_valid), 32'(e.rv));
        if (!e.cs_n) chk("R5 addr", 32'(sram_addr), 32'(e.addr));
        if (e.drv)   chk("R5 wdata", 32'(sram_dq_out), 32'(e.data));
        if (e.rv)    chk("R9/R6 rd_data", 32'(rd_data), 32'(e.data));
        // R4: controller and memory never drive together
        chk("R4 contention", 32'(sram_dq_oe && !sram_cs_n && sram_we_n && !sram_oe_n), 32'd0);
    endtask

    function automatic logic [14:0] addr_of(input int k);
        if (k == 0) return 15'h0000;
        if (k == 1) return 15'h7FFF;
        return 15'((k * 1237 + 91) & 32'h7FFF);
    endfunction

    initial begin
        exp_t e, idle_e;
        int op = 0, gap = 0, ncyc = 0;
        idle_e = '{rdy:1'b1, cs_n:1'b1, we_n:1'b1, oe_n:1'b1, drv:1'b0, rv:1'b0, addr:'0, data:'0};
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req = (i == 1);
            req_we = 1'b1;
            if (i > 0) compare(idle_e);
        end
        req = 1'b0;
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            ncyc++;
            e = (q.size() > 0) ? q.pop_front() : idle_e;
            compare(e);
            if (op == NOPS && q.size() == 0) break;
            if (e.rdy && op < NOPS && gap == 0) begin
                logic        we;
                logic [14:0] a;
                logic [7:0]  d;
                if (op < 16)      begin we = 1'b1; a = addr_of(op); end
                else if (op < 32) begin we = 1'b0; a = addr_of(op - 16); end
                else              begin we = (op % 2 == 0); a = addr_of(we ? op : op - 1); end
                d = 8'((op * 37 + 5) & 8'hFF);
                req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
                if (we) begin
                    // R3: address phase, strobe pulse, hold
                    for (int k = 0; k < TURN; k++) q.push_back('{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,a,d});
                    for (int k = 0; k < PW; k++)   q.push_back('{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,a,d});
                    for (int k = 0; k < HOLD; k++) q.push_back('{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,a,d});
                    exp_mem[int'(a)] = d;
                end else begin
                    // R6/R9: read phase then result in the idle cycle
                    logic [7:0] x;
                    x = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
                    for (int k = 0; k < RD; k++) q.push_back('{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,a,8'h00});
                    q.push_back('{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,15'h0,x});
                end
                op++;
                gap = op % 3;   // zero gap gives back-to-back requests (R7)
            end else if (e.rdy) begin
                req = 1'b0;
                if (gap > 0) gap--;
            end else begin
                // R2: requests while busy must be ignored
                req = (ncyc % 2 == 0);
                req_we = 1'b1; req_addr = 15'h5555; req_wdata = 8'hC3;
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule